// File: doc/BRIEF.md
# Coincidence Matrix Trigger

This block decides whether a particle crossed a chosen pair of strips on two detector planes. It takes one hit line per strip from a first plane and one from a second plane. For every possible pair (first-plane strip, second-plane strip), it forms a gated AND. Each pair has its own select bit held in a small on-block store, and the pair counts only when that bit is set. The gated results of all pairs are reduced by a balanced, registered OR tree. The tree output becomes a single one-cycle trigger pulse.

The trigger is produced a fixed number of clock cycles after the hits are sampled, whichever pair fired. Every pair passes through the same register stages. The timing reference is a separate path: the OR of the first-plane hits, delayed by exactly the depth of the matrix and tree. The OR tree supplies only the yes/no decision. A trigger is issued only when the decision and the first-plane reference agree in the same cycle.

Software or a configuration engine loads the select pattern through a simple write strobe. The pattern usually stays fixed during a run.

Top module: `cm_trig_top`

## Requirements
- R1: After a synchronous active-low reset, every select bit is 0 and both `trig_o` and `tref_o` are low. Hits alone then never raise `trig_o`.
- R2: When `sel_we_i` is high at a clock edge, the select bit of pair (a, b) takes `sel_data_i`. Here a = `sel_addr_i[9:5]` and b = `sel_addr_i[4:0]`. The new value applies to hits sampled at that same edge and at every later edge.
- R3: Suppose `hit_a_i[a]` and `hit_b_i[b]` are both high at one edge, the pair is selected, and no selected coincidence was present at the previous edge. Then `trig_o` is high exactly 8 cycles later. This latency is the same for every pair, the corner pairs included.
- R4: Hits on a pair whose select bit is 0 never cause a trigger.
- R5: A first-plane hit and a second-plane hit sampled at different edges do not form a coincidence.
- R6: Several selected coincidences sampled at the same edge give exactly one trigger pulse.
- R7: `trig_o` is one cycle wide. Hits held on a selected pair for several cycles give a single pulse. A new pulse needs at least one sampled edge without any selected coincidence.
- R8: `tref_o` equals the OR of all first-plane hit lines sampled 8 cycles earlier.
- R9: Writing 0 to a select bit disables that pair again.
- R10: `trig_o` is never high while `tref_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_a_i | input | 32 | First-plane hit lines, one per strip |
| hit_b_i | input | 32 | Second-plane hit lines, one per strip |
| sel_we_i | input | 1 | Select store write strobe |
| sel_addr_i | input | 10 | Pair address: [9:5] first-plane index, [4:0] second-plane index |
| sel_data_i | input | 1 | Select bit value to write |
| trig_o | output | 1 | One-cycle trigger pulse |
| tref_o | output | 1 | First-plane timing reference, aligned with the trigger |

## Verification
Four properties hold on every cycle:
- reset clears the store and both outputs;
- a write lands at the addressed pair in the next cycle;
- a trigger pulse is never two cycles wide;
- a trigger never appears without the first-plane reference.

The fixed 8-cycle latency across different pairs needs the bench scenarios, which drive the corner pairs and a pseudo-random hit stream against a reference model. The same holds for rejecting unselected or time-skewed hits, and for merging simultaneous or held coincidences into one pulse.

// File: rtl/cm_trig_pkg.sv
`timescale 1ns/1ps
// Package: sizing helpers for the coincidence matrix trigger.
// Assumes all arguments are positive; radix is at least 2.
package cm_trig_pkg;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Smaller of two integers.
    function automatic int min_int(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    // Number of nodes at a given level of a radix-r OR tree over n leaves.
    function automatic int level_width(input int n, input int r, input int lvl);
        int w;
        w = n;
        for (int k = 0; k < lvl; k++) w = ceil_div(w, r);
        return w;
    endfunction

    // Number of register levels needed to reduce n leaves to one node.
    function automatic int tree_levels(input int n, input int r);
        int w;
        int l;
        w = n;
        l = 0;
        while (w > 1) begin
            w = ceil_div(w, r);
            l++;
        end
        return l;
    endfunction

    // Bit offset of a level inside the flattened node vector.
    function automatic int level_offset(input int n, input int r, input int lvl);
        int off;
        off = 0;
        for (int k = 0; k < lvl; k++) off += level_width(n, r, k);
        return off;
    endfunction

endpackage

// File: rtl/cm_delay.sv
`timescale 1ns/1ps
// Module: cm_delay
// Fixed-depth register delay used to equalise path latencies.
// Assumes DEPTH >= 0; depth 0 is a plain wire.
module cm_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (DEPTH == 0) begin : g_wire
        assign q_o = d_i;
    end else begin : g_regs
        logic [W-1:0] stg [DEPTH];

        // First stage captures the input.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d_i;
        end

        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            // Each later stage copies its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end

        assign q_o = stg[DEPTH-1];
    end
endmodule

// File: rtl/cm_sel_store.sv
`timescale 1ns/1ps
// Module: cm_sel_store
// One select bit per pair, row-major by first-plane index.
// A single write strobe updates one bit; out-of-range indices are dropped.
// Assumes the store is static while hits flow, but tolerates live writes.
module cm_sel_store #(
    parameter int A_CH    = 32,
    parameter int B_CH    = 32,
    parameter int A_IDX_W = 5,
    parameter int B_IDX_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [A_IDX_W-1:0]     a_idx_i,
    input  logic [B_IDX_W-1:0]     b_idx_i,
    input  logic                   data_i,
    output logic [A_CH*B_CH-1:0]   sel_o
);
    localparam int PAIRS = A_CH * B_CH;
    localparam int POS_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [PAIRS-1:0] sel_q;
    logic [POS_W-1:0] wr_pos;
    logic             wr_ok;

    // Decode the flat bit position and its validity.
    always_comb begin
        wr_pos = POS_W'(int'(a_idx_i) * B_CH + int'(b_idx_i));
        wr_ok  = (int'(a_idx_i) < A_CH) && (int'(b_idx_i) < B_CH);
    end

    // Clear on reset, otherwise update the addressed bit.
    always_ff @(posedge clk) begin
        if (!rst_n)              sel_q <= '0;
        else if (we_i && wr_ok)  sel_q[wr_pos] <= data_i;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/cm_pair_grid.sv
`timescale 1ns/1ps
// Module: cm_pair_grid
// Forms every first-plane x second-plane AND, masks it with its select
// bit and registers the result: one stage, identical for every pair.
// Assumes both planes arrive already aligned to the same edge.
module cm_pair_grid #(
    parameter int A_CH = 32,
    parameter int B_CH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [A_CH-1:0]       a_i,
    input  logic [B_CH-1:0]       b_i,
    input  logic [A_CH*B_CH-1:0]  sel_i,
    output logic [A_CH*B_CH-1:0]  pair_o
);
    localparam int PAIRS = A_CH * B_CH;

    logic [PAIRS-1:0] prod;
    logic [PAIRS-1:0] pair_q;

    for (genvar ia = 0; ia < A_CH; ia++) begin : g_row
        for (genvar ib = 0; ib < B_CH; ib++) begin : g_col
            assign prod[ia*B_CH + ib] = a_i[ia] & b_i[ib];
        end
    end

    // Register the selected coincidences.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= prod & sel_i;
    end

    assign pair_o = pair_q;
endmodule

// File: rtl/cm_or_tree.sv
`timescale 1ns/1ps
// Module: cm_or_tree
// Balanced radix-R OR reduction with one register per level.
// Every leaf reaches the root through exactly LEVELS registers.
// Assumes N >= 2 and R >= 2.
module cm_or_tree #(
    parameter int N = 1024,
    parameter int R = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] leaves_i,
    output logic         any_o
);
    import cm_trig_pkg::*;

    localparam int LEVELS = tree_levels(N, R);
    localparam int TOTAL  = level_offset(N, R, LEVELS + 1);

    logic [TOTAL-1:0] node;

    assign node[N-1:0] = leaves_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int WI    = level_width(N, R, l);
        localparam int WO    = level_width(N, R, l + 1);
        localparam int OFF_I = level_offset(N, R, l);
        localparam int OFF_O = level_offset(N, R, l + 1);

        logic [WI-1:0] d;
        logic [WO-1:0] nxt;
        logic [WO-1:0] q;

        assign d = node[OFF_I +: WI];

        for (genvar o = 0; o < WO; o++) begin : g_node
            localparam int LO = o * R;
            localparam int HI = min_int(LO + R, WI) - 1;
            assign nxt[o] = |d[HI:LO];
        end

        // One register stage per tree level.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign node[OFF_O +: WO] = q;
    end

    assign any_o = node[TOTAL-1];
endmodule

// File: rtl/cm_trig_top.sv
`timescale 1ns/1ps
// Module: cm_trig_top
// Coincidence matrix trigger. Both planes pass equal input stages, the
// pair grid gates every pair by its select bit, and the OR tree reduces the
// result. The first-plane OR is delayed to the same depth and serves as the
// timing reference; a trigger needs decision and reference together and is
// emitted once per rising decision. Latency = IN_STAGES + TREE_LVLS + 2.
module cm_trig_top #(
    parameter int A_CH      = 32,
    parameter int B_CH      = 32,
    parameter int OR_RADIX  = 4,
    parameter int IN_STAGES = 1,
    parameter int A_IDX_W   = $clog2(A_CH),
    parameter int B_IDX_W   = $clog2(B_CH),
    parameter int ADDR_W    = A_IDX_W + B_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [A_CH-1:0]   hit_a_i,
    input  logic [B_CH-1:0]   hit_b_i,
    input  logic              sel_we_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    input  logic              sel_data_i,
    output logic              trig_o,
    output logic              tref_o
);
    import cm_trig_pkg::*;

    localparam int PAIRS     = A_CH * B_CH;
    localparam int TREE_LVLS = tree_levels(PAIRS, OR_RADIX);

    logic [A_CH-1:0]  a_eq;
    logic [B_CH-1:0]  b_eq;
    logic [PAIRS-1:0] sel_vec;
    logic [PAIRS-1:0] pair_q;
    logic             ref_q;
    logic             ref_al;
    logic             coin_any;
    logic             cond;
    logic             cond_q;
    logic             trig_q;
    logic             tref_q;

    cm_delay #(.W(A_CH), .DEPTH(IN_STAGES)) u_eq_a (
        .clk(clk), .rst_n(rst_n), .d_i(hit_a_i), .q_o(a_eq)
    );

    cm_delay #(.W(B_CH), .DEPTH(IN_STAGES)) u_eq_b (
        .clk(clk), .rst_n(rst_n), .d_i(hit_b_i), .q_o(b_eq)
    );

    cm_sel_store #(
        .A_CH(A_CH), .B_CH(B_CH), .A_IDX_W(A_IDX_W), .B_IDX_W(B_IDX_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (sel_we_i),
        .a_idx_i (sel_addr_i[ADDR_W-1 -: A_IDX_W]),
        .b_idx_i (sel_addr_i[B_IDX_W-1:0]),
        .data_i  (sel_data_i),
        .sel_o   (sel_vec)
    );

    cm_pair_grid #(.A_CH(A_CH), .B_CH(B_CH)) u_grid (
        .clk(clk), .rst_n(rst_n), .a_i(a_eq), .b_i(b_eq),
        .sel_i(sel_vec), .pair_o(pair_q)
    );

    cm_or_tree #(.N(PAIRS), .R(OR_RADIX)) u_tree (
        .clk(clk), .rst_n(rst_n), .leaves_i(pair_q), .any_o(coin_any)
    );

    // Reference path stage matching the pair grid register.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= |a_eq;
    end

    cm_delay #(.W(1), .DEPTH(TREE_LVLS)) u_ref_dly (
        .clk(clk), .rst_n(rst_n), .d_i(ref_q), .q_o(ref_al)
    );

    assign cond = coin_any & ref_al;

    // Output stage: edge-detect the decision and register the reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            trig_q <= 1'b0;
            tref_q <= 1'b0;
        end else begin
            cond_q <= cond;
            trig_q <= cond & ~cond_q;
            tref_q <= ref_al;
        end
    end

    assign trig_o = trig_q;
    assign tref_o = tref_q;
endmodule

// File: rtl/cm_trig_chk.sv
`timescale 1ns/1ps
// Module: cm_trig_chk
// Cycle-level properties of the coincidence matrix trigger, bound to the top.
module cm_trig_chk #(
    parameter int A_CH    = 32,
    parameter int B_CH    = 32,
    parameter int A_IDX_W = 5,
    parameter int B_IDX_W = 5,
    parameter int ADDR_W  = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_we_i,
    input logic [ADDR_W-1:0]    sel_addr_i,
    input logic                 sel_data_i,
    input logic [A_CH*B_CH-1:0] sel_vec,
    input logic                 trig_o,
    input logic                 tref_o
);
    localparam int PAIRS = A_CH * B_CH;
    localparam int POS_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [POS_W-1:0] wr_pos;
    logic             wr_ok;

    // Flat position and validity of the current write address.
    always_comb begin
        wr_pos = POS_W'(int'(sel_addr_i[ADDR_W-1 -: A_IDX_W]) * B_CH
                        + int'(sel_addr_i[B_IDX_W-1:0]));
        wr_ok  = (int'(sel_addr_i[ADDR_W-1 -: A_IDX_W]) < A_CH)
              && (int'(sel_addr_i[B_IDX_W-1:0]) < B_CH);
    end

    // R1: reset clears the store and both outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!trig_o && !tref_o && sel_vec == '0));

    // R2: a write lands at the addressed pair.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_we_i) && $past(wr_ok))
        |-> (sel_vec[$past(wr_pos)] == $past(sel_data_i)));

    // R7: the trigger pulse is a single cycle.
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R10: no trigger without the first-plane reference.
    a_r10_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> tref_o);
endmodule

bind cm_trig_top cm_trig_chk #(
    .A_CH(A_CH), .B_CH(B_CH), .A_IDX_W(A_IDX_W), .B_IDX_W(B_IDX_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_we_i   (sel_we_i),
    .sel_addr_i (sel_addr_i),
    .sel_data_i (sel_data_i),
    .sel_vec    (sel_vec),
    .trig_o     (trig_o),
    .tref_o     (tref_o)
);

// File: tb/cm_trig_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts trigger cycles from its own select
// model and queues them; the monitor compares outputs every cycle.
module cm_trig_top_tb_top;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ha = '0;
    logic [31:0] hb = '0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic        data = 1'b0;
    logic        trig_o;
    logic        tref_o;

    int    cyc = 0;
    int    errs = 0;
    int    checks = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    exp_q[$];
    bit    aany_hist[int];
    bit    m_sel[32][32];
    bit    m_prev = 1'b0;
    logic [31:0] rs = 32'h1234_5678;

    cm_trig_top dut_i (
        .clk(clk), .rst_n(rst_n), .hit_a_i(ha), .hit_b_i(hb),
        .sel_we_i(we), .sel_addr_i(addr), .sel_data_i(data),
        .trig_o(trig_o), .tref_o(tref_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endfunction

    // One driven cycle; the model updates and predicts the trigger.
    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input bit w = 1'b0, input int ia = 0, input int ib = 0,
                        input bit d = 1'b0);
        bit cond;
        @(posedge clk); #1;
        ha = a; hb = b; we = w; addr = {ia[4:0], ib[4:0]}; data = d;
        if (w) m_sel[ia][ib] = d;
        cond = 1'b0;
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                if (a[i] && b[j] && m_sel[i][j]) cond = 1'b1;
        if (cond && !m_prev) exp_q.push_back(cyc + LAT);
        m_prev = cond;
        aany_hist[cyc] = |a;
    endtask

    task automatic wr(input int ia, input int ib, input bit d);
        step('0, '0, 1'b1, ia, ib, d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step('0, '0);
    endtask

    task automatic hit(input int ia, input int ib);
        step(32'h1 << ia, 32'h1 << ib);
    endtask

    // Monitor: compare against the queued predictions away from the edge.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            bit exp_t;
            bit exp_r;
            exp_t = (exp_q.size() > 0) && (exp_q[0] == cyc);
            if (exp_t) void'(exp_q.pop_front());
            chk(trig_o === exp_t, cur_req, int'(trig_o), int'(exp_t));
            exp_r = aany_hist.exists(cyc - LAT) ? aany_hist[cyc - LAT] : 1'b0;
            chk(tref_o === exp_r, "R8", int'(tref_o), int'(exp_r));
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(trig_o === 1'b0, "R1", int'(trig_o), 0);
        chk(tref_o === 1'b0, "R1", int'(tref_o), 0);
        mon_en = 1'b1;

        // R1: nothing is selected after reset, so no trigger.
        cur_req = "R1";
        for (int k = 0; k < 3; k++) step('1, '1);
        idle(12);

        // R2 and R3: one selected pair fires with the fixed latency.
        cur_req = "R2";
        wr(3, 7, 1'b1);
        hit(3, 7);
        idle(12);

        // R3: corner pairs share the same latency.
        cur_req = "R3";
        wr(0, 0, 1'b1);  hit(0, 0);  idle(10);
        wr(31, 31, 1'b1); hit(31, 31); idle(10);
        wr(0, 31, 1'b1); hit(0, 31); idle(10);
        wr(31, 0, 1'b1); hit(31, 0); idle(12);

        // R4: an unselected pair stays silent.
        cur_req = "R4";
        hit(5, 5);
        hit(3, 8);
        idle(12);

        // R5: skewed hits on a selected pair do not coincide.
        cur_req = "R5";
        step(32'h1 << 3, '0);
        step('0, 32'h1 << 7);
        idle(12);

        // R6: several selected coincidences at one edge give one pulse.
        cur_req = "R6";
        step((32'h1 << 3) | 32'h1 | (32'h1 << 31), (32'h1 << 7) | 32'h1 | (32'h1 << 31));
        idle(12);

        // R7: held hits pulse once; a gap re-arms the trigger.
        cur_req = "R7";
        for (int k = 0; k < 5; k++) hit(3, 7);
        idle(1);
        for (int k = 0; k < 3; k++) hit(3, 7);
        idle(12);

        // R9: clearing a select bit disables the pair again.
        cur_req = "R9";
        wr(3, 7, 1'b0);
        hit(3, 7);
        idle(12);

        // R3 and R8: sparse pseudo-random hits against the model.
        cur_req = "R3";
        wr(10, 20, 1'b1);
        wr(17, 2, 1'b1);
        for (int k = 0; k < 300; k++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            ra = rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            ra = ra & rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            rb = rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            rb = rb & rs;
            step(ra, rb);
        end
        idle(12);

        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule